// File: doc/BRIEF.md
# CAN bit timing prescaler

This block divides the system clock down to the CAN time quantum and steps each bit time through three parts: a one-quantum synchronization segment, a first phase segment (TSEG1) and a second phase segment (TSEG2). It pulses a strobe when the bus should be sampled, which is the end of TSEG1. It pulses a second strobe at the end of each bit. A falling (recessive-to-dominant) transition on the received line can move the sample point: it either stretches TSEG1 or trims TSEG2, within a programmable jump limit.

The quantum length and the jump limit come from one 8-bit configuration byte. The byte can only be written while a configuration-change enable input is high, and reset leaves it as it was. The two segment lengths come in on their own inputs. They are held steady while the block runs.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration byte holds the jump field in bits 7:6 and the prescaler value P in bits 5:0. A write updates the byte on the clock edge where `cfg_we` and `cfg_unlock` are both high. P may be any value from 0 to 63.
- R2: A write made while `cfg_unlock` is low leaves the byte unchanged. This holds both during reset and during operation.
- R3: Reset does not change the configuration byte. During reset all three strobes stay low.
- R4: `tq_tick` is a one-clock pulse. It repeats every 2*(P+1) clocks. The first pulse comes 2*(P+1) clocks after the first clock edge with reset released.
- R5: With no resynchronization, a bit lasts 1+T1+T2 quanta, where T1 is `tseg1_len` and T2 is `tseg2_len`. `sample_stb` fires on the tick that ends quantum T1, counting the sync quantum as quantum 0. `bit_stb` fires on the tick that ends the last quantum. The two never coincide, and each bit has exactly one sample before its end.
- R6: An edge is a change of `rx_bit` from 1 on one clock to 0 on the next, seen while `rx_edge_en` is high. When `rx_edge_en` is low, transitions are ignored.
- R7: An edge in TSEG1 quantum q (q from 1 to T1) extends TSEG1 by min(q, J+1) quanta, where J is the jump field. This delays the sample strobe and the bit end by the same amount.
- R8: An edge in TSEG2 quantum q shortens TSEG2 by min(T1+T2-q, J+1) quanta. This is the number of quanta left after the current one, capped by the jump limit.
- R9: An edge in the sync quantum has no effect. Only the first edge in a bit is acted on. An edge that arrives on the same clock as a tick counts as belonging to the quantum that begins next.
- R10: The prescaler and the quantum count both restart at every bit boundary. So the first tick of a bit comes 2*(P+1) clocks after the `bit_stb` of the previous bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (configuration byte excluded) |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_unlock | input | 1 | Configuration-change enable; writes count only while high |
| cfg_wdata | input | 8 | Configuration byte: jump field [7:6], prescaler [5:0] |
| tseg1_len | input | 4 | TSEG1 length in quanta, at least 1 |
| tseg2_len | input | 4 | TSEG2 length in quanta, at least 2 |
| rx_bit | input | 1 | Received bus level, 1 = recessive |
| rx_edge_en | input | 1 | Enables resynchronization on falling edges of rx_bit |
| tq_tick | output | 1 | One-clock pulse at the end of each quantum |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| bit_stb | output | 1 | One-clock pulse at the end of each bit |

## Verification
The hardest cases to reach are edges placed on a chosen quantum. Some must fall mid-quantum and others exactly on a tick clock, because a tick-cycle edge moves to the next quantum and can cross a segment or bit boundary. The stimulus reads the bench's own model of the quantum index and prescaler phase. It waits for the wanted quantum and phase, then drops `rx_bit` for one clock. This places edges in the sync quantum, deep in TSEG1 so the jump limit clips the correction, in the last TSEG2 quantum, on the sample tick and on the bit-end tick. A second edge in the same bit, and an edge while edge detection is disabled, are also placed this way.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int SEGW = 4,
  parameter int BRPW = 6,
  parameter int SJWW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_unlock,
  input  logic [SJWW+BRPW-1:0] cfg_wdata,
  input  logic [SEGW-1:0]      tseg1_len,
  input  logic [SEGW-1:0]      tseg2_len,
  input  logic                 rx_bit,
  input  logic                 rx_edge_en,
  output logic                 tq_tick,
  output logic                 sample_stb,
  output logic                 bit_stb
);
  localparam int CFGW = SJWW + BRPW;
  localparam int PCW  = BRPW + 1;
  localparam int QW   = SEGW + 2;
  localparam int ADJW = SJWW + 1;

  logic [CFGW-1:0] cfg_q;
  logic [PCW-1:0]  pcnt;
  logic [QW-1:0]   qidx;
  logic [ADJW-1:0] ext, shr;
  logic            done, rx_prev;

  wire [PCW-1:0]  plast  = {cfg_q[BRPW-1:0], 1'b1};
  wire [ADJW-1:0] jump   = {1'b0, cfg_q[CFGW-1 -: SJWW]} + 1'b1;
  wire [QW-1:0]   t1_end = QW'(tseg1_len) + QW'(ext);
  wire [QW-1:0]   b_end  = t1_end + QW'(tseg2_len) - QW'(shr);

  assign tq_tick    = pcnt >= plast;
  assign sample_stb = tq_tick && (qidx == t1_end);
  assign bit_stb    = tq_tick && (qidx == b_end);

  wire [QW-1:0] qnext  = bit_stb ? '0 : qidx + QW'(tq_tick);
  wire          in_ts1 = (qnext != '0) && (qnext <= t1_end);
  wire [QW-1:0] err    = in_ts1 ? qnext : QW'(tseg1_len) + QW'(tseg2_len) - qnext;
  wire [ADJW-1:0] adj  = (err < QW'(jump)) ? err[ADJW-1:0] : jump;
  wire          edge_hit = rx_edge_en & rx_prev & ~rx_bit;
  wire          resync   = edge_hit & ~done & ~bit_stb & (qnext != '0);

  always_ff @(posedge clk)
    if (cfg_we && cfg_unlock) cfg_q <= cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      qidx    <= '0;
      ext     <= '0;
      shr     <= '0;
      done    <= 1'b0;
      rx_prev <= 1'b1;
    end else begin
      pcnt    <= tq_tick ? '0 : pcnt + 1'b1;
      qidx    <= qnext;
      rx_prev <= rx_bit;
      if (bit_stb) begin
        ext  <= '0;
        shr  <= '0;
        done <= 1'b0;
      end else if (resync) begin
        done <= 1'b1;
        if (in_ts1) ext <= adj;
        else        shr <= adj;
      end
    end
  end
endmodule

module can_bit_timer_chk #(
  parameter int CFGW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            cfg_unlock,
  input logic [CFGW-1:0] cfg_q,
  input logic            tq_tick,
  input logic            sample_stb,
  input logic            bit_stb
);
  logic seen_sample;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          seen_sample <= 1'b0;
    else if (bit_stb)    seen_sample <= 1'b0;
    else if (sample_stb) seen_sample <= 1'b1;

  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_unlock) |=> $stable(cfg_q));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |=> !tq_tick);

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_stb));

  a_r5_sample_before_end: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> seen_sample);

  a_r5_one_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !seen_sample);
endmodule

bind can_bit_timer can_bit_timer_chk #(.CFGW(CFGW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unlock(cfg_unlock),
  .cfg_q(cfg_q), .tq_tick(tq_tick), .sample_stb(sample_stb), .bit_stb(bit_stb)
);

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_unlock = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [3:0] tseg1 = 4'd5, tseg2 = 4'd3;
  logic rx = 1'b1, en = 1'b1;
  logic tq_tick, sample_stb, bit_stb;

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_on = 1'b0;
  string tag = "R3";

  always #4 clk = ~clk;

  can_bit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unlock(cfg_unlock),
    .cfg_wdata(cfg_wdata), .tseg1_len(tseg1), .tseg2_len(tseg2),
    .rx_bit(rx), .rx_edge_en(en),
    .tq_tick(tq_tick), .sample_stb(sample_stb), .bit_stb(bit_stb)
  );

  // Behavioural reference model
  int m_cfg = 0, m_pc = 0, m_q = 0, m_ext = 0, m_shr = 0;
  bit m_done = 0, m_prev = 1;
  bit e_tick = 0, e_samp = 0, e_bit = 0;

  always @(posedge clk) begin
    int brp, sj, last, t1, be, qn, e;
    bit tk, bend, hit;
    if (cfg_we && cfg_unlock) m_cfg = cfg_wdata;
    brp = m_cfg % 64; sj = m_cfg / 64 + 1; last = 2 * (brp + 1) - 1;
    if (!rst_n) begin
      m_pc = 0; m_q = 0; m_ext = 0; m_shr = 0; m_done = 0; m_prev = 1;
    end else begin
      tk = m_pc >= last;
      t1 = tseg1 + m_ext;
      be = t1 + tseg2 - m_shr;
      bend = tk && m_q == be;
      qn = tk ? (bend ? 0 : m_q + 1) : m_q;
      hit = en && m_prev && !rx;
      if (bend) begin
        m_ext = 0; m_shr = 0; m_done = 0;
      end else if (hit && !m_done && qn != 0) begin
        if (qn <= tseg1) m_ext = (qn < sj) ? qn : sj;
        else begin
          e = tseg1 + tseg2 - qn;
          m_shr = (e < sj) ? e : sj;
        end
        m_done = 1;
      end
      m_pc = tk ? 0 : m_pc + 1;
      m_q = qn;
      m_prev = rx;
    end
    e_tick = rst_n && m_pc >= last;
    e_samp = e_tick && m_q == tseg1 + m_ext;
    e_bit  = e_tick && m_q == tseg1 + m_ext + tseg2 - m_shr;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if ({tq_tick, sample_stb, bit_stb} !== {e_tick, e_samp, e_bit}) begin
        fails++;
        $display("FAIL %s: tick/sample/bit actual %b%b%b expected %b%b%b at %0t",
                 tag, tq_tick, sample_stb, bit_stb, e_tick, e_samp, e_bit, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tg, act, exp);
    end
  endtask

  task automatic reset_cfg(input logic [7:0] w, input bit unl, input int t1, input int t2);
    @(negedge clk); #1;
    rst_n = 1'b0; cfg_we = 1'b1; cfg_unlock = unl; cfg_wdata = w;
    tseg1 = 4'(t1); tseg2 = 4'(t2);
    @(negedge clk); #1;
    cfg_we = 1'b0; cfg_unlock = 1'b0; cmp_on = 1'b1;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!e_bit) @(negedge clk);
    end
  endtask

  task automatic pulse_edge(input int qt, input bit on_tick);
    @(negedge clk);
    while (!(m_q == qt && (on_tick ? e_tick : (!e_tick && m_pc == 0)))) @(negedge clk);
    #1 rx = 1'b0;
    @(negedge clk); #1 rx = 1'b1;
  endtask

  task automatic measure_period(input int exp, input string tg);
    int n;
    n = 0;
    @(negedge clk);
    while (!tq_tick) @(negedge clk);
    do begin @(negedge clk); n++; end while (!tq_tick);
    chk(n == exp, tg, n, exp);
  endtask

  task automatic measure_after_bit(input int exp);
    int n;
    n = 0;
    @(negedge clk);
    while (!bit_stb) @(negedge clk);
    do begin @(negedge clk); n++; end while (!tq_tick);
    chk(n == exp, "R10 first tick after bit end", n, exp);
  endtask

  initial begin
    // R1: jump field 1, prescaler 1 -> 4-clock quanta; T1=5, T2=3
    tag = "R3 reset state";
    reset_cfg(8'h41, 1'b1, 5, 3);
    tag = "R4/R5 nominal";
    measure_period(4, "R1 R4 quantum length P=1");
    wait_bits(2);
    tag = "R7 TSEG1 edge"; pulse_edge(1, 1'b0); wait_bits(1);
    tag = "R7 clamp"; pulse_edge(4, 1'b0); wait_bits(1);
    tag = "R8 TSEG2 edge"; pulse_edge(7, 1'b0); wait_bits(1);
    tag = "R8 clamp"; pulse_edge(6, 1'b0); wait_bits(1);
    tag = "R8 last quantum"; pulse_edge(8, 1'b0); wait_bits(1);
    tag = "R9 sync edge"; pulse_edge(0, 1'b0); wait_bits(1);
    tag = "R9 second edge"; pulse_edge(2, 1'b0); pulse_edge(6, 1'b0); wait_bits(1);
    tag = "R9 edge on sample tick"; pulse_edge(5, 1'b1); wait_bits(1);
    tag = "R9 edge on bit-end tick"; pulse_edge(8, 1'b1); wait_bits(2);
    tag = "R6 edge disabled";
    en = 1'b0; pulse_edge(2, 1'b0); wait_bits(1); en = 1'b1;
    measure_after_bit(4);

    // R2/R3: locked write during reset, byte must survive reset
    tag = "R2 locked write";
    reset_cfg(8'hFF, 1'b0, 5, 3);
    measure_period(4, "R2 R3 quantum after locked write and reset");
    wait_bits(2);

    // Minimum prescaler and segments
    tag = "R5 minimum";
    reset_cfg(8'h00, 1'b1, 1, 2);
    measure_period(2, "R1 R4 quantum length P=0");
    wait_bits(2);
    tag = "R7 minimum"; pulse_edge(1, 1'b0); wait_bits(1);
    tag = "R8 minimum"; pulse_edge(2, 1'b0); wait_bits(2);
    measure_after_bit(2);

    // Large jump, longer quanta
    tag = "R5 wide";
    reset_cfg(8'hC3, 1'b1, 8, 4);
    measure_period(8, "R1 R4 quantum length P=3");
    tag = "R7 wide jump"; pulse_edge(6, 1'b0); wait_bits(1);
    tag = "R8 wide jump"; pulse_edge(10, 1'b0); wait_bits(1);
    tag = "R2 locked write in operation";
    @(negedge clk); #1 cfg_we = 1'b1; cfg_wdata = 8'h00;
    @(negedge clk); #1 cfg_we = 1'b0;
    measure_period(8, "R2 quantum unchanged after locked write");
    measure_after_bit(8);

    // Largest prescaler
    tag = "R4 P=63";
    reset_cfg(8'h3F, 1'b1, 3, 2);
    measure_period(128, "R1 R4 quantum length P=63");
    wait_bits(1);

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule